// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block is the device-side front end of a serial flash model that handles the two erase commands of the array. It accepts an 8-bit opcode followed by a 24-bit address over a serial port while chip select is low. Clock polarity may be idle-low or idle-high (SPI modes 0 and 3). It maps the address to a block or sector of the main array. Two page-size modes are supported, and each places the page number at a different bit offset in the address.

The erase commits only when chip select returns high after a complete 32-bit frame. At that point the block emits a one-cycle start pulse together with the erase type and the decoded location. It then holds a self-timed busy period, whose length is a parameter in clock cycles. During that period the ready/busy pin, the status ready bit and an erase request output to the array all report the erase in progress. Frames that finish while the block is busy are dropped.

All serial pins are brought into the system clock domain through synchronisers and sampled there. The system clock must run well above the serial clock.

Top module: `nor_erase_decoder`

## Requirements
- R1: Bits are taken MSB first on each rising edge of `spi_sck` while `spi_cs_n` is low, whether the clock idles low (mode 0) or high (mode 3); the first 8 bits form the opcode and the next 24 form the address `a[23:0]`.
- R2: Opcode 0x50 is a block erase and reports `erase_kind`=0 with a 10-bit block index. The index is `a[22:13]` when `page_512`=0 (528-byte pages) and `a[21:12]` when `page_512`=1 (512-byte pages). `erase_sector` carries the top 6 index bits and `erase_sub_b`=0.
- R3: Opcode 0x7C is a sector erase and reports `erase_kind`=1. `erase_sector` is the top 6 bits of the 10-bit index from R2. For sectors 1 to 63, `erase_block` is sector×16 and the lower four index bits have no effect.
- R4: For sector 0, all ten index bits are decoded. An index of 0 selects the small piece 0a, giving `erase_block`=0 and `erase_sub_b`=0. Any nonzero index selects piece 0b, giving `erase_block`=1 and `erase_sub_b`=1.
- R5: A valid erase begins only after `spi_cs_n` rises. `erase_start` is high for exactly one cycle. `erase_kind`, `erase_block`, `erase_sector` and `erase_sub_b` change only in that cycle and hold their value until the next start.
- R6: A frame with fewer than 32 bits before chip select rises starts no erase. Bits after the 32nd are ignored.
- R7: A complete frame with any opcode other than 0x50 or 0x7C starts no erase.
- R8: From the `erase_start` cycle onward, for exactly `ERASE_CYCLES` cycles, `rdy_busy_n`=0, `status_ready`=0 and `erase_req`=1. Outside that window they read 1, 1 and 0.
- R9: A frame whose chip-select rise falls inside the busy window is ignored. It produces no start, leaves the reported fields unchanged and does not stretch the busy window.
- R10: After reset the block reads ready (`rdy_busy_n`=1, `status_ready`=1, `erase_req`=0), `erase_start` is 0 and all reported fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_512 | input | 1 | Page-size mode: 1 for 512-byte pages, 0 for 528-byte pages |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| erase_start | output | 1 | One-cycle pulse when an erase begins |
| erase_kind | output | 1 | 0 for block erase, 1 for sector erase |
| erase_block | output | 10 | Block index, or first block of the erased sector piece |
| erase_sector | output | 6 | Sector number |
| erase_sub_b | output | 1 | Sector erase of piece 0b |
| erase_req | output | 1 | Erase request to the array, high while busy |
| status_ready | output | 1 | Status ready bit, 0 while busy |
| rdy_busy_n | output | 1 | Ready/busy pin, low while busy |

## Verification
The hardest case to reach is a complete, well-formed frame whose chip-select rise lands inside the busy window. The busy window must be longer than a whole serial frame, and the second frame must be sent right after the first one commits. The bench therefore sets the erase duration above the length of one frame and sends a second, different command as soon as the first start pulse appears. It then checks that the reported fields still describe the first command and that the busy window keeps its length. Truncated frames, frames longer than 32 bits, unknown opcodes and the sector-0 split are mixed into the random traffic. Both clock polarities and both page modes are exercised.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
  localparam int OP_W    = 8;
  localparam int ADDR_W  = 24;
  localparam int FRAME_W = OP_W + ADDR_W;
  localparam int BLK_W   = 10;
  localparam int SUB_W   = 4;
  localparam int SEC_W   = BLK_W - SUB_W;
  localparam int LSB_528 = 13;
  localparam int LSB_512 = 12;

  localparam logic [OP_W-1:0] OPC_BLOCK  = 8'h50;
  localparam logic [OP_W-1:0] OPC_SECTOR = 8'h7C;

  typedef enum logic {
    KIND_BLOCK  = 1'b0,
    KIND_SECTOR = 1'b1
  } erase_kind_e;

  typedef struct packed {
    erase_kind_e        kind;
    logic [BLK_W-1:0]   block;
    logic [SEC_W-1:0]   sector;
    logic               sub_b;
  } erase_cmd_t;
endpackage

// File: rtl/erase_sync.sv
module erase_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/erase_frame_rx.sv
module erase_frame_rx
  import nor_erase_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_full,
  output logic               cs_rise
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               sck_d, cs_d;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic [FRAME_W-1:0] sh_q, sh_nx;
  logic               sck_rise;

  assign sck_rise   = sck_s & ~sck_d;
  assign cs_rise    = cs_n_s & ~cs_d;
  assign frame_full = (cnt_q == CNT_W'(FRAME_W));
  assign frame      = sh_q;

  always_comb begin
    cnt_nx = cnt_q;
    sh_nx  = sh_q;
    if (cs_n_s) begin
      cnt_nx = '0;
    end else if (sck_rise && !frame_full) begin
      sh_nx  = {sh_q[FRAME_W-2:0], mosi_s};
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
      cnt_q <= cnt_nx;
      sh_q  <= sh_nx;
    end
  end
endmodule

// File: rtl/erase_addr_map.sv
module erase_addr_map
  import nor_erase_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  input  logic               page_512,
  output erase_cmd_t         cmd,
  output logic               cmd_ok
);
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] addr;
  logic [BLK_W-1:0]  idx;
  logic [SEC_W-1:0]  sec;
  logic              sec_zero;

  assign opcode   = frame[FRAME_W-1 -: OP_W];
  assign addr     = frame[ADDR_W-1:0];
  assign idx      = page_512 ? addr[LSB_512 +: BLK_W] : addr[LSB_528 +: BLK_W];
  assign sec      = idx[BLK_W-1 -: SEC_W];
  assign sec_zero = (sec == '0);

  always_comb begin
    cmd_ok     = 1'b0;
    cmd.kind   = KIND_BLOCK;
    cmd.block  = idx;
    cmd.sector = sec;
    cmd.sub_b  = 1'b0;
    unique case (opcode)
      OPC_BLOCK: begin
        cmd_ok = 1'b1;
      end
      OPC_SECTOR: begin
        cmd_ok   = 1'b1;
        cmd.kind = KIND_SECTOR;
        if (sec_zero) begin
          cmd.sub_b = |idx[SUB_W-1:0];
          cmd.block = BLK_W'(cmd.sub_b);
        end else begin
          cmd.block = {sec, {SUB_W{1'b0}}};
        end
      end
      default: cmd_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/erase_busy_timer.sv
module erase_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (load)              cnt_nx = CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nor_erase_decoder.sv
module nor_erase_decoder
  import nor_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_512,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             erase_start,
  output logic             erase_kind,
  output logic [BLK_W-1:0] erase_block,
  output logic [SEC_W-1:0] erase_sector,
  output logic             erase_sub_b,
  output logic             erase_req,
  output logic             status_ready,
  output logic             rdy_busy_n
);
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] frame;
  logic               frame_full, cs_rise;
  erase_cmd_t         cmd_dec, cmd_q;
  logic               cmd_ok, busy;
  logic               start_nx, start_q;

  erase_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  erase_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (pins_s[2]),
    .cs_n_s     (pins_s[1]),
    .mosi_s     (pins_s[0]),
    .frame      (frame),
    .frame_full (frame_full),
    .cs_rise    (cs_rise)
  );

  erase_addr_map u_map (
    .frame    (frame),
    .page_512 (page_512),
    .cmd      (cmd_dec),
    .cmd_ok   (cmd_ok)
  );

  assign start_nx = cs_rise & frame_full & cmd_ok & ~busy;

  erase_busy_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_nx),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      start_q <= start_nx;
      if (start_nx) cmd_q <= cmd_dec;
    end
  end

  assign erase_start  = start_q;
  assign erase_kind   = cmd_q.kind;
  assign erase_block  = cmd_q.block;
  assign erase_sector = cmd_q.sector;
  assign erase_sub_b  = cmd_q.sub_b;
  assign erase_req    = busy;
  assign status_ready = ~busy;
  assign rdy_busy_n   = ~busy;
endmodule

// File: rtl/nor_erase_decoder_chk.sv
module nor_erase_decoder_chk
  import nor_erase_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             erase_start,
  input logic             erase_kind,
  input logic [BLK_W-1:0] erase_block,
  input logic [SEC_W-1:0] erase_sector,
  input logic             erase_sub_b,
  input logic             erase_req,
  input logic             rdy_busy_n
);
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  a_r8_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (!rdy_busy_n && erase_req));

  a_r9_start_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(rdy_busy_n));

  a_r8_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_busy_n) |-> erase_start);

  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_start |-> ($stable(erase_block) && $stable(erase_kind) &&
                      $stable(erase_sector) && $stable(erase_sub_b)));

  a_r4_sub_only_sector0: assert property (@(posedge clk) disable iff (!rst_n)
    erase_sub_b |-> (erase_kind && erase_sector == '0 && erase_block == 10'd1));
endmodule

bind nor_erase_decoder nor_erase_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .erase_start  (erase_start),
  .erase_kind   (erase_kind),
  .erase_block  (erase_block),
  .erase_sector (erase_sector),
  .erase_sub_b  (erase_sub_b),
  .erase_req    (erase_req),
  .rdy_busy_n   (rdy_busy_n)
);

// File: tb/tb_nor_erase_decoder.sv
module tb_nor_erase_decoder;
  localparam int EC   = 300;
  localparam int HALF = 3;

  logic clk, rst_n, page_512, spi_sck, spi_cs_n, spi_mosi;
  logic erase_start, erase_kind, erase_sub_b, erase_req, status_ready, rdy_busy_n;
  logic [9:0] erase_block;
  logic [5:0] erase_sector;

  nor_erase_decoder #(.ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .page_512(page_512),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .erase_start(erase_start), .erase_kind(erase_kind),
    .erase_block(erase_block), .erase_sector(erase_sector),
    .erase_sub_b(erase_sub_b), .erase_req(erase_req),
    .status_ready(status_ready), .rdy_busy_n(rdy_busy_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0, starts = 0, run = 0, last_len = 0;
  bit done = 0;
  logic [17:0] cap;

  always @(negedge clk) begin
    if (rst_n) begin
      if (erase_start) begin
        starts++;
        cap = {erase_kind, erase_block, erase_sector, erase_sub_b};
      end
      if (!rdy_busy_n) run++;
      else if (run != 0) begin last_len = run; run = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {valid, kind, block[9:0], sector[5:0], sub}
  function automatic logic [18:0] expect_cmd(input logic [7:0] op, input logic [23:0] a, input bit p512);
    logic [9:0] idx;
    logic [5:0] sec;
    logic sub;
    idx = p512 ? a[21:12] : a[22:13];
    sec = idx[9:4];
    if (op == 8'h50) return {1'b1, 1'b0, idx, sec, 1'b0};
    if (op == 8'h7C) begin
      if (sec == 6'd0) begin
        sub = |idx[3:0];
        return {1'b1, 1'b1, 9'd0, sub, sec, sub};
      end
      return {1'b1, 1'b1, sec, 4'd0, sec, 1'b0};
    end
    return '0;
  endfunction

  task automatic send(input bit mode3, input int nbits, input logic [39:0] d);
    @(negedge clk);
    spi_sck  = mode3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sck  = 1'b0;
      spi_mosi = d[39-i];
      repeat (HALF) @(negedge clk);
      spi_sck  = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_sck = mode3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
  endtask

  task automatic wait_ready();
    repeat (3) @(negedge clk);
    while (!rdy_busy_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input string req, input bit mode3, input bit p512,
                         input int nbits, input logic [7:0] op, input logic [23:0] a);
    int s0;
    logic [18:0] e;
    logic [17:0] prev;
    page_512 = p512;
    s0 = starts;
    prev = cap;
    e = (nbits >= 32) ? expect_cmd(op, a, p512) : 19'd0;
    send(mode3, nbits, {op, a, 8'hA5});
    repeat (8) @(negedge clk);
    if (e[18]) begin
      check(starts == s0 + 1, req, starts - s0, 1);
      check(cap == e[17:0], req, cap, e[17:0]);
      wait_ready();
      check(last_len == EC, {req, " R8 busy length"}, last_len, EC);
    end else begin
      check(starts == s0 && rdy_busy_n, req, starts - s0, 0);
      check(cap == prev, {req, " fields"}, cap, prev);
    end
  endtask

  initial begin
    rst_n = 1'b0; page_512 = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    cap = '0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R10 reset state
    check(rdy_busy_n && status_ready && !erase_req && !erase_start, "R10 status",
          {rdy_busy_n, status_ready, erase_req, erase_start}, 4'b1100);
    check({erase_kind, erase_block, erase_sector, erase_sub_b} == 18'd0, "R10 fields",
          {erase_kind, erase_block, erase_sector, erase_sub_b}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed cases
    run_cmd("R2 block 528 mode0 R1", 0, 0, 32, 8'h50, 24'h7FE000);
    run_cmd("R2 block 512 mode3 R1", 1, 1, 32, 8'h50, 24'h3FF000);
    run_cmd("R3 sector 63 low bits ignored", 0, 0, 32, 8'h7C, 24'h7FFFFF);
    run_cmd("R4 sector 0a", 1, 0, 32, 8'h7C, 24'h001FFF);
    run_cmd("R4 sector 0b", 0, 1, 32, 8'h7C, 24'h00F000);
    run_cmd("R6 truncated frame", 0, 0, 31, 8'h50, 24'h123456);
    run_cmd("R6 extra bits ignored", 1, 1, 40, 8'h7C, 24'h2A5000);
    run_cmd("R7 unknown opcode", 0, 0, 32, 8'h52, 24'h100000);

    // R9: second command committed while busy
    begin
      int s0;
      logic [17:0] e1;
      page_512 = 1'b0;
      e1 = expect_cmd(8'h50, 24'h246000, 0);
      s0 = starts;
      send(0, 32, {8'h50, 24'h246000, 8'h00});
      repeat (8) @(negedge clk);
      send(1, 32, {8'h7C, 24'h7F0000, 8'h00});
      repeat (8) @(negedge clk);
      check(!rdy_busy_n, "R9 still busy at second commit", rdy_busy_n, 0);
      check(starts == s0 + 1, "R9 no second start", starts - s0, 1);
      wait_ready();
      check(cap == e1, "R9 fields unchanged", cap, e1);
      check(last_len == EC, "R9 busy not stretched", last_len, EC);
    end

    // Constrained random traffic
    for (int it = 0; it < 30; it++) begin
      bit m3, p;
      int sel, nb;
      logic [7:0] op;
      logic [23:0] a;
      m3 = 1'($urandom % 2);
      p = 1'($urandom % 2);
      sel = int'($urandom % 8);
      a = 24'($urandom);
      nb = 32;
      if (sel < 3) op = 8'h50;
      else if (sel < 6) begin
        op = 8'h7C;
        if (sel == 5) a = a & (p ? 24'hC0FFFF : 24'h81FFFF);  // hits sector 0 (R4)
      end else begin
        op = 8'($urandom);
        if (op == 8'h50 || op == 8'h7C) op = 8'h00;
        if (sel == 7) begin op = 8'h50; nb = 1 + int'($urandom % 31); end
      end
      run_cmd("R1 R2 R3 R4 R6 R7 random", m3, p, nb, op, a);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule